// File: doc/BRIEF.md
# Ordered Store Buffer with Fence Markers

The block is a first-in first-out store queue between a core's retirement stage and its level-one data cache. Retired stores enter it in program order. A store can be ordinary, in which case it drains to the cache port, or non-temporal, in which case it drains to a write-combining path. Fence instructions also enter the queue as marker entries. The block drains one entry per clock, strictly from the oldest, whenever the target port can take it. There is no deliberate holding of a store, so slots are released for later stores as early as possible.

Fences behave according to a strong memory model. A store fence stays at the head only while non-temporal data that has already left the queue is still unflushed. In that case it requests a flush of the write-combining path and leaves on the acknowledge. A full fence flushes in the same way. It also holds a load-side stall that keeps younger loads away from the cache until the queue is completely empty. A load fence needs no drain, so it is accepted and discarded. Younger loads that hit a buffered ordinary store receive its data by forwarding from the youngest match.

Top module: `store_order_buf`

## Requirements
- R1: Entries leave in exactly the order they were accepted, taken across both drain ports together, and at most one entry leaves per clock.
- R2: An ordinary store (kind code 0) at the head is shown on the cache port in that same cycle. It leaves at the clock edge where cm_ready is high.
- R3: A non-temporal store (kind code 1) is shown only on the write-combining port and leaves when wc_ready is high. The cache port, the write-combining port and the flush request are never active together.
- R4: A fence (kind code 2 for store fence, 3 for full fence) may reach the head after a non-temporal store has left since the last flush. It then raises wc_flush_req and holds it until wc_flush_ack, and leaves at the acknowledge edge. Entries behind it wait.
- R5: A store fence that reaches the head with no non-temporal store owed leaves in that same cycle with no flush request. The next entry is at the head one cycle later.
- R6: Store fences and load fences (kind codes 4 to 7) never raise ld_stall. A load fence takes no slot and causes no activity on any drain port.
- R7: After a full fence is accepted, ld_stall is high from the next cycle. It stays high until the cycle after the last entry leaves the queue. While ld_stall is high, no load is forwarded.
- R8: sb_full is high exactly when all DEPTH slots hold entries, and an enqueue offered while sb_full is high is dropped. An enqueue and a drain in the same cycle leave the occupancy unchanged.
- R9: A load (ld_valid) whose address matches buffered ordinary stores gets ld_fwd_hit together with the data of the youngest match. Non-temporal stores and dropped enqueues are never forwarded.
- R10: A synchronous reset empties the queue and clears the owed-flush state and the load stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Retired entry offered |
| enq_kind | input | 3 | 0 store, 1 non-temporal store, 2 store fence, 3 full fence, 4-7 load fence |
| enq_addr | input | 16 | Store address |
| enq_data | input | 32 | Store data |
| sb_full | output | 1 | All slots occupied; enqueue dropped |
| cm_valid | output | 1 | Ordinary store offered to the cache |
| cm_addr | output | 16 | Cache write address |
| cm_data | output | 32 | Cache write data |
| cm_ready | input | 1 | Cache accepts the write |
| wc_valid | output | 1 | Non-temporal store offered to write-combining path |
| wc_addr | output | 16 | Write-combining address |
| wc_data | output | 32 | Write-combining data |
| wc_ready | input | 1 | Write-combining path accepts the store |
| wc_flush_req | output | 1 | Flush of write-combining path requested by a fence |
| wc_flush_ack | input | 1 | Flush complete, data globally visible |
| ld_valid | input | 1 | Younger load probing the buffer |
| ld_addr | input | 16 | Load address |
| ld_stall | output | 1 | Younger loads blocked by a pending full fence |
| ld_fwd_hit | output | 1 | Load served by forwarding |
| ld_fwd_data | output | 32 | Forwarded data |

## Verification
Directed sequences cover several cases. One fills the queue behind a stalled cache port to tell apart full, dropped-enqueue and simultaneous push/pop occupancy, and forwarding with a duplicated address. Another runs non-temporal stores followed by each fence kind, to tell an owed flush from a free fence pass. A third places a full fence between two stores to time the stall release against the last drain. A seeded random phase then mixes all kinds with random readiness and flush acknowledges. Order is checked against a bench queue of accepted stores, and the bench confirms that forwarding never occurs under a stall.

// File: rtl/sob_pkg.sv
package sob_pkg;

    parameter int unsigned SOB_AW = 16;
    parameter int unsigned SOB_DW = 32;

    typedef enum logic [1:0] {
        EK_STORE   = 2'd0,
        EK_NTSTORE = 2'd1,
        EK_SFENCE  = 2'd2,
        EK_MFENCE  = 2'd3
    } ent_kind_e;

    typedef struct packed {
        ent_kind_e          kind;
        logic [SOB_AW-1:0]  addr;
        logic [SOB_DW-1:0]  data;
    } sob_entry_t;

    // Codes 4..7 are load fences: they never occupy a slot.
    function automatic logic takes_slot(input logic [2:0] code);
        return code[2] == 1'b0;
    endfunction

    function automatic logic is_fence(input ent_kind_e k);
        return (k == EK_SFENCE) || (k == EK_MFENCE);
    endfunction

endpackage

// File: rtl/sob_ring.sv
module sob_ring
    import sob_pkg::*;
#(
    parameter  int unsigned DEPTH = 8,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  sob_entry_t       push_ent,
    input  logic             pop,
    output sob_entry_t       head_ent,
    output logic [PTR_W-1:0] head_ptr,
    output logic [CNT_W-1:0] cnt,
    output logic             full,
    output logic             empty,
    output sob_entry_t       slots_o [DEPTH]
);

    sob_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] tail_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[tail_ptr] <= push_ent;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_ptr <= '0;
            tail_ptr <= '0;
            cnt      <= '0;
        end else begin
            if (push) tail_ptr <= bump(tail_ptr);
            if (pop)  head_ptr <= bump(head_ptr);
            cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign full     = (cnt == CNT_W'(DEPTH));
    assign empty    = (cnt == '0);
    assign head_ent = mem[head_ptr];
    assign slots_o  = mem;

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        !(push && full));

    a_r1_no_underflow: assert property (@(posedge clk) disable iff (rst)
        !(pop && empty));

    a_r8_count_up: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |=> (cnt == $past(cnt) + 1'b1));

    a_r8_count_hold: assert property (@(posedge clk) disable iff (rst)
        (push && pop) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/sob_drain.sv
module sob_drain
    import sob_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              head_vld,
    input  sob_entry_t        head_ent,
    input  logic              cm_ready,
    input  logic              wc_ready,
    input  logic              wc_flush_ack,
    output logic              cm_valid,
    output logic [SOB_AW-1:0] cm_addr,
    output logic [SOB_DW-1:0] cm_data,
    output logic              wc_valid,
    output logic [SOB_AW-1:0] wc_addr,
    output logic [SOB_DW-1:0] wc_data,
    output logic              wc_flush_req,
    output logic              pop
);

    // Set once a non-temporal store has gone to the write-combining path
    // and no flush has completed since.
    logic nt_owed;

    always_comb begin
        cm_valid     = 1'b0;
        wc_valid     = 1'b0;
        wc_flush_req = 1'b0;
        pop          = 1'b0;
        if (head_vld) begin
            if (is_fence(head_ent.kind)) begin
                wc_flush_req = nt_owed;
                pop          = !nt_owed || wc_flush_ack;
            end else if (head_ent.kind == EK_NTSTORE) begin
                wc_valid = 1'b1;
                pop      = wc_ready;
            end else begin
                cm_valid = 1'b1;
                pop      = cm_ready;
            end
        end
    end

    assign cm_addr = head_ent.addr;
    assign cm_data = head_ent.data;
    assign wc_addr = head_ent.addr;
    assign wc_data = head_ent.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            nt_owed <= 1'b0;
        end else if (wc_valid && wc_ready) begin
            nt_owed <= 1'b1;
        end else if (wc_flush_req && wc_flush_ack) begin
            nt_owed <= 1'b0;
        end
    end

    a_r3_port_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cm_valid, wc_valid, wc_flush_req}));

    a_r4_flush_hold: assert property (@(posedge clk) disable iff (rst)
        (wc_flush_req && !wc_flush_ack) |=> wc_flush_req);

    a_r4_flush_done: assert property (@(posedge clk) disable iff (rst)
        (wc_flush_req && wc_flush_ack) |=> !wc_flush_req);

endmodule

// File: rtl/sob_fwd.sv
module sob_fwd
    import sob_pkg::*;
#(
    parameter  int unsigned DEPTH = 8,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  sob_entry_t        slots [DEPTH],
    input  logic [PTR_W-1:0]  head_ptr,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              ld_valid,
    input  logic [SOB_AW-1:0] ld_addr,
    input  logic              blocked,
    output logic              hit,
    output logic [SOB_DW-1:0] data
);

    // Per-slot match, independent of age.
    logic [DEPTH-1:0] slot_match;

    for (genvar g = 0; g < DEPTH; g++) begin : g_match
        assign slot_match[g] = (slots[g].kind == EK_STORE) &&
                               (slots[g].addr == ld_addr);
    end

    // Walk from oldest to youngest; later matches override earlier ones.
    logic [PTR_W-1:0] k;
    always_comb begin
        hit  = 1'b0;
        data = '0;
        k    = '0;
        for (int i = 0; i < DEPTH; i++) begin
            k = PTR_W'((int'(head_ptr) + i) % DEPTH);
            if ((CNT_W'(i) < cnt) && slot_match[k] && ld_valid && !blocked) begin
                hit  = 1'b1;
                data = slots[k].data;
            end
        end
    end

endmodule

// File: rtl/store_order_buf.sv
module store_order_buf
    import sob_pkg::*;
#(
    parameter  int unsigned DEPTH = 8,
    localparam int unsigned AW    = SOB_AW,
    localparam int unsigned DW    = SOB_DW,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enq_valid,
    input  logic [2:0]    enq_kind,
    input  logic [AW-1:0] enq_addr,
    input  logic [DW-1:0] enq_data,
    output logic          sb_full,
    output logic          cm_valid,
    output logic [AW-1:0] cm_addr,
    output logic [DW-1:0] cm_data,
    input  logic          cm_ready,
    output logic          wc_valid,
    output logic [AW-1:0] wc_addr,
    output logic [DW-1:0] wc_data,
    input  logic          wc_ready,
    output logic          wc_flush_req,
    input  logic          wc_flush_ack,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    output logic          ld_stall,
    output logic          ld_fwd_hit,
    output logic [DW-1:0] ld_fwd_data
);

    sob_entry_t       push_ent;
    sob_entry_t       head_ent;
    sob_entry_t       slots [DEPTH];
    logic [PTR_W-1:0] head_ptr;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_next;
    logic             push;
    logic             pop;
    logic             empty;
    logic             mf_block;

    assign push          = enq_valid && !sb_full && takes_slot(enq_kind);
    assign push_ent.kind = ent_kind_e'(enq_kind[1:0]);
    assign push_ent.addr = enq_addr;
    assign push_ent.data = enq_data;

    sob_ring #(.DEPTH(DEPTH)) u_ring (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_ent (push_ent),
        .pop      (pop),
        .head_ent (head_ent),
        .head_ptr (head_ptr),
        .cnt      (cnt),
        .full     (sb_full),
        .empty    (empty),
        .slots_o  (slots)
    );

    sob_drain u_drain (
        .clk          (clk),
        .rst          (rst),
        .head_vld     (!empty),
        .head_ent     (head_ent),
        .cm_ready     (cm_ready),
        .wc_ready     (wc_ready),
        .wc_flush_ack (wc_flush_ack),
        .cm_valid     (cm_valid),
        .cm_addr      (cm_addr),
        .cm_data      (cm_data),
        .wc_valid     (wc_valid),
        .wc_addr      (wc_addr),
        .wc_data      (wc_data),
        .wc_flush_req (wc_flush_req),
        .pop          (pop)
    );

    sob_fwd #(.DEPTH(DEPTH)) u_fwd (
        .slots    (slots),
        .head_ptr (head_ptr),
        .cnt      (cnt),
        .ld_valid (ld_valid),
        .ld_addr  (ld_addr),
        .blocked  (mf_block),
        .hit      (ld_fwd_hit),
        .data     (ld_fwd_data)
    );

    // Full-fence load block: raised on acceptance, dropped once empty.
    assign cnt_next = cnt + CNT_W'(push) - CNT_W'(pop);

    always_ff @(posedge clk) begin
        if (rst) begin
            mf_block <= 1'b0;
        end else if (push && (push_ent.kind == EK_MFENCE)) begin
            mf_block <= 1'b1;
        end else if (cnt_next == '0) begin
            mf_block <= 1'b0;
        end
    end

    assign ld_stall = mf_block;

    a_r7_release_empty: assert property (@(posedge clk) disable iff (rst)
        $fell(ld_stall) |-> (cnt == '0));

    a_r7_no_fwd_stalled: assert property (@(posedge clk) disable iff (rst)
        ld_fwd_hit |-> !ld_stall);

    a_r6_lfence_no_stall: assert property (@(posedge clk) disable iff (rst)
        (enq_valid && enq_kind[2] && !ld_stall) |=> !ld_stall);

endmodule

// File: tb/store_order_buf_tb.sv
`timescale 1ns/1ps
module store_order_buf_tb;

    localparam int DEPTH = 8;
    localparam int AW    = 16;
    localparam int DW    = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enq_valid = 1'b0;
    logic [2:0]    enq_kind = 3'd0;
    logic [AW-1:0] enq_addr = '0;
    logic [DW-1:0] enq_data = '0;
    logic          cm_ready = 1'b0;
    logic          wc_ready = 1'b0;
    logic          wc_flush_ack = 1'b0;
    logic          ld_valid = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic          sb_full, cm_valid, wc_valid, wc_flush_req;
    logic          ld_stall, ld_fwd_hit;
    logic [AW-1:0] cm_addr, wc_addr;
    logic [DW-1:0] cm_data, wc_data, ld_fwd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [AW-1:0] q_addr [$];
    logic [DW-1:0] q_data [$];
    bit            q_nt   [$];

    always #10 clk = ~clk;

    store_order_buf #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_kind(enq_kind),
        .enq_addr(enq_addr), .enq_data(enq_data), .sb_full(sb_full),
        .cm_valid(cm_valid), .cm_addr(cm_addr), .cm_data(cm_data),
        .cm_ready(cm_ready), .wc_valid(wc_valid), .wc_addr(wc_addr),
        .wc_data(wc_data), .wc_ready(wc_ready), .wc_flush_req(wc_flush_req),
        .wc_flush_ack(wc_flush_ack), .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_stall(ld_stall), .ld_fwd_hit(ld_fwd_hit), .ld_fwd_data(ld_fwd_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle();
        enq_valid    = 1'b0;
        ld_valid     = 1'b0;
        wc_flush_ack = 1'b0;
    endtask

    task automatic put(input logic [2:0] k, input logic [AW-1:0] a,
                       input logic [DW-1:0] d);
        enq_valid = 1'b1;
        enq_kind  = k;
        enq_addr  = a;
        enq_data  = d;
    endtask

    // Monitor: samples shortly before each rising edge.
    always begin
        @(negedge clk);
        #8;
        if (rst) begin
            q_addr.delete(); q_data.delete(); q_nt.delete();
        end else begin
            chk($countones({cm_valid, wc_valid, wc_flush_req}) <= 1, "R3 port exclusive",
                {cm_valid, wc_valid, wc_flush_req}, 0);
            if (ld_stall)
                chk(!ld_fwd_hit, "R7 no forward under stall", ld_fwd_hit, 0);
            if (cm_valid && cm_ready) begin
                if (q_addr.size() == 0) begin
                    chk(0, "R1 commit with nothing accepted", cm_addr, 0);
                end else begin
                    chk(!q_nt[0] && cm_addr == q_addr[0] && cm_data == q_data[0],
                        "R1/R2 cache order", {cm_addr, cm_data}, {q_addr[0], q_data[0]});
                    void'(q_addr.pop_front()); void'(q_data.pop_front()); void'(q_nt.pop_front());
                end
            end
            if (wc_valid && wc_ready) begin
                if (q_addr.size() == 0) begin
                    chk(0, "R1 wc drain with nothing accepted", wc_addr, 0);
                end else begin
                    chk(q_nt[0] && wc_addr == q_addr[0] && wc_data == q_data[0],
                        "R1/R3 wc order", {wc_addr, wc_data}, {q_addr[0], q_data[0]});
                    void'(q_addr.pop_front()); void'(q_data.pop_front()); void'(q_nt.pop_front());
                end
            end
            if (enq_valid && !sb_full && enq_kind < 3'd2) begin
                q_addr.push_back(enq_addr);
                q_data.push_back(enq_data);
                q_nt.push_back(enq_kind == 3'd1);
            end
        end
    end

    initial begin
        #4_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) step();
        rst = 1'b0;
        #8;
        // R10: reset state
        chk(!sb_full && !cm_valid && !wc_valid && !wc_flush_req && !ld_stall,
            "R10 reset outputs", {sb_full, cm_valid, wc_valid, wc_flush_req, ld_stall}, 0);

        // ---- D1: fill, full, refuse, forwarding, simultaneous push/pop (R8, R9)
        cm_ready = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            step();
            put(3'd0, (i == 5) ? 16'h0102 : 16'h0100 + 16'(i), (i == 5) ? 32'h55 : 32'(i));
        end
        step(); idle(); #8;
        chk(sb_full, "R8 full after DEPTH", sb_full, 1);
        step(); put(3'd0, 16'h01FF, 32'hDEAD); #8;
        chk(sb_full, "R8 still full on refused enqueue", sb_full, 1);
        step(); idle(); ld_valid = 1'b1; ld_addr = 16'h0102; #8;
        chk(ld_fwd_hit && ld_fwd_data == 32'h55, "R9 youngest match",
            {ld_fwd_hit, ld_fwd_data}, {1'b1, 32'h55});
        step(); ld_addr = 16'h0104; #8;
        chk(ld_fwd_hit && ld_fwd_data == 32'h4, "R9 single match",
            {ld_fwd_hit, ld_fwd_data}, {1'b1, 32'h4});
        step(); ld_addr = 16'h01FF; #8;
        chk(!ld_fwd_hit, "R9 dropped enqueue not forwarded", ld_fwd_hit, 0);
        step(); idle(); cm_ready = 1'b1; #8;
        chk(cm_valid && cm_addr == 16'h0100, "R2 head on cache port", cm_addr, 16'h0100);
        step(); put(3'd0, 16'h0120, 32'h120); #8;
        chk(!sb_full, "R8 not full after one pop", sb_full, 0);
        step(); cm_ready = 1'b0; put(3'd0, 16'h0121, 32'h121); #8;
        chk(!sb_full, "R8 simultaneous push/pop kept count", sb_full, 0);
        step(); idle(); #8;
        chk(sb_full, "R8 full again", sb_full, 1);
        step(); cm_ready = 1'b1;
        repeat (12) step();
        #8;
        chk(q_addr.size() == 0 && !cm_valid, "R1 all drained in order", q_addr.size(), 0);

        // ---- D2: store fence with and without owed flush (R3, R4, R5, R6, R9)
        step(); wc_ready = 1'b1; put(3'd1, 16'h0200, 32'h2000);
        step(); put(3'd2, 16'h0, 32'h0); ld_valid = 1'b1; ld_addr = 16'h0200; #8;
        chk(wc_valid && wc_addr == 16'h0200 && !cm_valid, "R3 nt on wc port",
            {wc_valid, wc_addr}, {1'b1, 16'h0200});
        chk(!ld_fwd_hit, "R9 nt not forwarded", ld_fwd_hit, 0);
        step(); put(3'd0, 16'h0201, 32'h2010); ld_valid = 1'b0; #8;
        chk(wc_flush_req, "R4 store fence requests flush", wc_flush_req, 1);
        chk(!ld_stall, "R6 store fence no stall", ld_stall, 0);
        step(); idle(); #8;
        chk(wc_flush_req && !cm_valid, "R4 hold, younger waits", {wc_flush_req, cm_valid}, 2'b10);
        step(); wc_flush_ack = 1'b1; #8;
        chk(wc_flush_req, "R4 req at ack", wc_flush_req, 1);
        step(); wc_flush_ack = 1'b0; #8;
        chk(!wc_flush_req && cm_valid && cm_addr == 16'h0201, "R4 fence left on ack",
            {wc_flush_req, cm_valid, cm_addr}, {2'b01, 16'h0201});
        step(); put(3'd2, 16'h0, 32'h0);
        step(); put(3'd0, 16'h0202, 32'h2020); #8;
        chk(!wc_flush_req && !cm_valid, "R5 free fence no flush", {wc_flush_req, cm_valid}, 0);
        step(); idle(); #8;
        chk(cm_valid && cm_addr == 16'h0202, "R5 next entry one cycle later",
            {cm_valid, cm_addr}, {1'b1, 16'h0202});

        // ---- D3: full fence stall window, load fence (R7, R6)
        step(); cm_ready = 1'b0; put(3'd0, 16'h0300, 32'h3000);
        step(); put(3'd3, 16'h0, 32'h0);
        step(); put(3'd0, 16'h0301, 32'h3010); ld_valid = 1'b1; ld_addr = 16'h0300; #8;
        chk(ld_stall && !ld_fwd_hit, "R7 stall and no forward", {ld_stall, ld_fwd_hit}, 2'b10);
        step(); idle(); cm_ready = 1'b1; #8;
        chk(cm_valid && cm_addr == 16'h0300, "R7 older store drains", cm_addr, 16'h0300);
        step(); #8;
        chk(!cm_valid && ld_stall, "R7 fence at head, still stalled", {cm_valid, ld_stall}, 2'b01);
        step(); #8;
        chk(cm_valid && cm_addr == 16'h0301 && ld_stall, "R7 stall until empty",
            {cm_valid, ld_stall}, 2'b11);
        step(); ld_valid = 1'b1; ld_addr = 16'h0301; #8;
        chk(!ld_stall && !ld_fwd_hit, "R7 stall released after empty", {ld_stall, ld_fwd_hit}, 0);
        step(); idle(); put(3'd4, 16'h0301, 32'h0);
        step(); idle(); #8;
        chk(!ld_stall && !cm_valid && !wc_valid && !wc_flush_req, "R6 load fence no effect",
            {ld_stall, cm_valid, wc_valid, wc_flush_req}, 0);

        // ---- D4: full fence with owed flush (R4, R7)
        step(); put(3'd1, 16'h0210, 32'h2100);
        step(); put(3'd3, 16'h0, 32'h0);
        step(); idle(); #8;
        chk(wc_flush_req && ld_stall, "R4 full fence flushes", {wc_flush_req, ld_stall}, 2'b11);
        step(); wc_flush_ack = 1'b1;
        step(); wc_flush_ack = 1'b0; #8;
        chk(!wc_flush_req && !ld_stall, "R7 released after fence left", {wc_flush_req, ld_stall}, 0);

        // ---- D5: reset mid-operation (R10)
        step(); cm_ready = 1'b0; put(3'd0, 16'h0500, 32'h5000);
        step(); put(3'd3, 16'h0, 32'h0);
        step(); idle(); rst = 1'b1;
        step(); rst = 1'b0; cm_ready = 1'b1; #8;
        chk(!cm_valid && !ld_stall && !sb_full && !wc_flush_req, "R10 reset clears state",
            {cm_valid, ld_stall, sb_full, wc_flush_req}, 0);

        // ---- Random phase
        for (int n = 0; n < 600; n++) begin
            step();
            begin
                int r;
                r = int'($urandom % 10);
                enq_valid = ($urandom % 2) == 1;
                enq_kind  = (r < 5) ? 3'd0 : (r < 7) ? 3'd1 : (r == 7) ? 3'd2 :
                            (r == 8) ? 3'd3 : 3'd4;
                enq_addr  = 16'h0400 + 16'($urandom % 8);
                enq_data  = $urandom;
                cm_ready  = ($urandom % 4) != 0;
                wc_ready  = ($urandom % 3) != 0;
                wc_flush_ack = wc_flush_req && (($urandom % 2) == 1);
                ld_valid  = ($urandom % 2) == 1;
                ld_addr   = 16'h0400 + 16'($urandom % 8);
            end
        end
        step(); idle(); cm_ready = 1'b1; wc_ready = 1'b1;
        for (int n = 0; n < 40; n++) begin
            step();
            wc_flush_ack = wc_flush_req;
        end
        step(); idle(); #8;
        chk(q_addr.size() == 0, "R1 random stream fully drained", q_addr.size(), 0);
        chk(!ld_stall, "R7 stall clear when drained", ld_stall, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule